// File: doc/BRIEF.md
# Program-Counter Return Stack with Register Window

This block keeps the return addresses of a small processor core. When the core calls a subroutine or enters an interrupt handler, it raises a push strobe together with the address where execution must later resume. When it executes a return of either kind, it raises a pop strobe and takes the saved address from a combinational output in that same cycle. The stack holds eight 11-bit addresses. A 3-bit pointer starts at the highest slot and moves downward as addresses are saved.

Each slot is also visible to software as two byte registers in the system register space. The low byte carries address bits 7:0. The high byte carries address bits 10:8 in its lowest three bits. A separate pointer register holds the current pointer in its low bits and the global interrupt-enable flag in its top bit, so software can inspect, rebuild or relocate the stack and switch interrupts on or off. The pointer wraps silently when it goes past either end, and nothing signals an overflow.

Top module: `pc_return_stack`

## Requirements
- R1: After reset the pointer is 7, the interrupt-enable flag (`irq_en_o`) is 0, and every slot holds 0.
- R2: A push writes `push_pc_i` into the slot the pointer selects and, at the same clock edge, lowers the pointer by one, wrapping from 0 to 7.
- R3: `pop_pc_o` always shows the slot at pointer+1 (modulo 8), which is the value a pop returns in that cycle. A pop raises the pointer by one, wrapping from 7 to 0.
- R4: When push and pop are high in the same cycle, the push is carried out and the pop is ignored.
- R5: Pushes followed by pops return the saved addresses in reverse order. A ninth push with no pop in between silently overwrites the oldest slot.
- R6: Slot n (0..7) appears at byte address 0xF0+2n for address bits 7:0 and at 0xF1+2n for address bits 10:8, held in data bits 2:0. Software can read and write both registers.
- R7: The pointer register is at byte address 0xE0. Bit 7 is the interrupt-enable flag, which drives `irq_en_o`, and bits 2:0 are the pointer. A write updates both fields.
- R8: Unimplemented bits read as 0 and writes to them are ignored. These are bits 6:3 of the pointer register and bits 7:3 of each high-byte register. An address outside 0xE0 and 0xF0..0xFF reads 0 and a write to it changes nothing.
- R9: In the same cycle, a push or pop takes priority over a software write to the pointer field, but the interrupt-enable bit still takes the written value. A push also takes priority over a software write to the slot the push targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save `push_pc_i` (call or interrupt entry) |
| pop_i | input | 1 | Restore an address (return or interrupt return) |
| push_pc_i | input | 11 | Address to save on a push |
| pop_pc_o | output | 11 | Address a pop returns this cycle |
| reg_wr_i | input | 1 | Software register write strobe |
| reg_addr_i | input | 8 | Software register byte address |
| reg_wdata_i | input | 8 | Software register write data |
| reg_rdata_o | output | 8 | Software register read data, combinational from `reg_addr_i` |
| irq_en_o | output | 1 | Global interrupt-enable flag |

## Verification
The hardest situations to reach are collisions between the core and software in one cycle. These include a push or pop that meets a pointer-register write, and a push whose target slot is being written through its byte registers. Ordinary call and return traffic never produces them. The directed part of the stimulus builds each collision on purpose, including the pointer wrapping at both ends. A seeded random phase then drives push, pop and register writes together, with addresses biased toward the mapped registers so that such collisions recur often. Every cycle, the stack output and the register read data are compared against a model of the stack.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    // Which software-visible register a byte address selects
    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_PTR  = 2'd1,
        RSEL_LO   = 2'd2,
        RSEL_HI   = 2'd3
    } rsel_e;

endpackage

// File: rtl/rstk_pointer.sv
module rstk_pointer #(
    parameter int DEPTH = 8,
    parameter int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             wr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic             gie_o
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
        logic             gie;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.gie = wdata_i[DW-1];
            st_d.ptr = wdata_i[PTR_W-1:0];
        end
        // stack traffic overrides a software pointer write
        if (push_i) begin
            st_d.ptr = st_q.ptr - PTR_W'(1);
        end else if (pop_i) begin
            st_d.ptr = st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ptr <= PTR_W'(DEPTH - 1);
            st_q.gie <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr_o = st_q.ptr;
    assign gie_o = st_q.gie;

    assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (ptr_o == $past(ptr_o) - PTR_W'(1)));

    assert_pop_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (ptr_o == $past(ptr_o) + PTR_W'(1)));

    // R9: the enable bit follows a software write even during stack traffic
    assert_gie_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (gie_o == $past(wdata_i[DW-1])));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i && !wr_i) |=> ($stable(ptr_o) && $stable(gie_o)));

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 11,
    parameter int DW    = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int HI_W  = PC_W - DW
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        push_i,
    input  logic [PTR_W-1:0]            ptr_i,
    input  logic [PC_W-1:0]             push_pc_i,
    input  logic                        wr_lo_i,
    input  logic                        wr_hi_i,
    input  logic [PTR_W-1:0]            widx_i,
    input  logic [DW-1:0]               wdata_i,
    output logic [DEPTH-1:0][PC_W-1:0]  ent_o
);

    typedef struct packed {
        logic [DEPTH-1:0][PC_W-1:0] ent;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (wr_lo_i && (widx_i == PTR_W'(i))) begin
                st_d.ent[i][DW-1:0] = wdata_i;
            end
            if (wr_hi_i && (widx_i == PTR_W'(i))) begin
                st_d.ent[i][PC_W-1:DW] = wdata_i[HI_W-1:0];
            end
            // a push wins over a software write to the same slot
            if (push_i && (ptr_i == PTR_W'(i))) begin
                st_d.ent[i] = push_pc_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_o = st_q.ent;

    assert_push_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (ent_o[$past(ptr_i)] == $past(push_pc_i)));

    assert_push_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && (wr_lo_i || wr_hi_i) && (widx_i == ptr_i))
            |=> (ent_o[$past(ptr_i)] == $past(push_pc_i)));

endmodule

// File: rtl/rstk_regport.sv
module rstk_regport
    import rstk_pkg::*;
#(
    parameter int         DEPTH    = 8,
    parameter int         PC_W     = 11,
    parameter int         DW       = 8,
    parameter int         AW       = 8,
    parameter logic [7:0] PTR_ADDR = 8'hE0,
    parameter logic [7:0] ENT_BASE = 8'hF0,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int SPAN  = 2 * DEPTH
) (
    input  logic [AW-1:0]               addr_i,
    input  logic                        wr_i,
    input  logic [PTR_W-1:0]            ptr_i,
    input  logic                        gie_i,
    input  logic [DEPTH-1:0][PC_W-1:0]  ent_i,
    output logic                        wr_ptr_o,
    output logic                        wr_lo_o,
    output logic                        wr_hi_o,
    output logic [PTR_W-1:0]            idx_o,
    output logic [DW-1:0]               rdata_o
);

    rsel_e         sel;
    logic [AW-1:0] off;
    logic [PC_W-1:0] slot;

    always_comb begin
        off   = addr_i - AW'(ENT_BASE);
        sel   = RSEL_NONE;
        idx_o = off[PTR_W:1];
        if (addr_i == AW'(PTR_ADDR)) begin
            sel = RSEL_PTR;
        end else if ((addr_i >= AW'(ENT_BASE)) && (off < AW'(SPAN))) begin
            sel = off[0] ? RSEL_HI : RSEL_LO;
        end
    end

    assign wr_ptr_o = wr_i && (sel == RSEL_PTR);
    assign wr_lo_o  = wr_i && (sel == RSEL_LO);
    assign wr_hi_o  = wr_i && (sel == RSEL_HI);
    assign slot     = ent_i[idx_o];

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            RSEL_PTR: begin
                rdata_o[DW-1]      = gie_i;
                rdata_o[PTR_W-1:0] = ptr_i;
            end
            RSEL_LO:  rdata_o            = slot[DW-1:0];
            RSEL_HI:  rdata_o[PC_W-DW-1:0] = slot[PC_W-1:DW];
            default:  rdata_o            = '0;
        endcase
    end

    always_comb begin
        assert_one_target_R8: assert ($countones({wr_ptr_o, wr_lo_o, wr_hi_o}) <= 1);
    end

endmodule

// File: rtl/pc_return_stack.sv
module pc_return_stack #(
    parameter int         DEPTH    = 8,
    parameter int         PC_W     = 11,
    parameter int         DW       = 8,
    parameter int         AW       = 8,
    parameter logic [7:0] PTR_ADDR = 8'hE0,
    parameter logic [7:0] ENT_BASE = 8'hF0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_i,
    input  logic            pop_i,
    input  logic [PC_W-1:0] push_pc_i,
    output logic [PC_W-1:0] pop_pc_o,
    input  logic            reg_wr_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    output logic            irq_en_o
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [PTR_W-1:0]           ptr;
    logic                       gie;
    logic [DEPTH-1:0][PC_W-1:0] ent;
    logic                       wr_ptr, wr_lo, wr_hi;
    logic [PTR_W-1:0]           widx;

    rstk_regport #(
        .DEPTH(DEPTH), .PC_W(PC_W), .DW(DW), .AW(AW),
        .PTR_ADDR(PTR_ADDR), .ENT_BASE(ENT_BASE)
    ) i_regport (
        .addr_i  (reg_addr_i),
        .wr_i    (reg_wr_i),
        .ptr_i   (ptr),
        .gie_i   (gie),
        .ent_i   (ent),
        .wr_ptr_o(wr_ptr),
        .wr_lo_o (wr_lo),
        .wr_hi_o (wr_hi),
        .idx_o   (widx),
        .rdata_o (reg_rdata_o)
    );

    rstk_pointer #(.DEPTH(DEPTH), .DW(DW)) i_pointer (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push_i),
        .pop_i  (pop_i),
        .wr_i   (wr_ptr),
        .wdata_i(reg_wdata_i),
        .ptr_o  (ptr),
        .gie_o  (gie)
    );

    rstk_store #(.DEPTH(DEPTH), .PC_W(PC_W), .DW(DW)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_i),
        .ptr_i    (ptr),
        .push_pc_i(push_pc_i),
        .wr_lo_i  (wr_lo),
        .wr_hi_i  (wr_hi),
        .widx_i   (widx),
        .wdata_i  (reg_wdata_i),
        .ent_o    (ent)
    );

    // the slot a pop would return is the one just above the pointer
    assign pop_pc_o = ent[ptr + PTR_W'(1)];
    assign irq_en_o = gie;

    assert_lifo_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !reg_wr_i) ##1 (pop_i && !push_i)
            |-> (pop_pc_o == $past(push_pc_i)));

endmodule

// File: tb/test_pc_return_stack.sv
module test_pc_return_stack;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_PTR  = 8'hE0;
    localparam logic [7:0] A_BASE = 8'hF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push = 1'b0, pop = 1'b0, wr = 1'b0;
    logic [10:0] push_pc = '0;
    logic [7:0]  addr = '0, wdata = '0;
    logic [10:0] pop_pc;
    logic [7:0]  rdata;
    logic        irq_en;

    int checks = 0;
    int fails  = 0;

    // model state
    logic [10:0] m_ent [8];
    logic [2:0]  m_sp;
    logic        m_gie;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pc_return_stack i_pc_return_stack (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .push_pc_i(push_pc), .pop_pc_o(pop_pc),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_en_o(irq_en)
    );

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        logic [2:0] idx;
        if (a == A_PTR) return {m_gie, 4'b0000, m_sp};
        if (a >= A_BASE) begin
            idx = 3'((a - A_BASE) >> 1);
            if (a[0]) return {5'b00000, m_ent[idx][10:8]};
            return m_ent[idx][7:0];
        end
        return 8'h00;
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic model_update(input logic p, input logic q, input logic [10:0] pc,
                                input logic w, input logic [7:0] a, input logic [7:0] d);
        logic [2:0] sp_n;
        logic [2:0] idx;
        sp_n = m_sp;
        if (w && a == A_PTR) begin
            m_gie = d[7];
            sp_n  = d[2:0];
        end else if (w && a >= A_BASE) begin
            idx = 3'((a - A_BASE) >> 1);
            if (a[0]) m_ent[idx][10:8] = d[2:0];
            else      m_ent[idx][7:0]  = d;
        end
        if (p) begin
            m_ent[m_sp] = pc;
            sp_n = m_sp - 3'd1;
        end else if (q) begin
            sp_n = m_sp + 3'd1;
        end
        m_sp = sp_n;
    endtask

    // one clock cycle: drive, check combinational outputs, update model
    task automatic step(input string tag, input logic p, input logic q, input logic [10:0] pc,
                        input logic w, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        push = p; pop = q; push_pc = pc; wr = w; addr = a; wdata = d;
        #1;
        chk(tag, "pop_pc_o", int'(pop_pc), int'(m_ent[m_sp + 3'd1]));
        chk(tag, "reg_rdata_o", int'(rdata), int'(exp_rd(a)));
        chk(tag, "irq_en_o", int'(irq_en), int'(m_gie));
        @(posedge clk);
        model_update(p, q, pc, w, a, d);
    endtask

    task automatic rd(input string tag, input logic [7:0] a);
        step(tag, 1'b0, 1'b0, 11'd0, 1'b0, a, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) m_ent[i] = '0;
        m_sp = 3'd7;
        m_gie = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values through every register
        rd("R1", A_PTR);
        for (int i = 0; i < 16; i++) rd("R1", A_BASE + 8'(i));

        // R2: pushes store and move the pointer down, wrapping 0 -> 7
        for (int i = 0; i < 9; i++)
            step("R2", 1'b1, 1'b0, 11'(16'h100 * i + 16'h23 + i), 1'b0, A_PTR, 8'h00);
        rd("R2", A_PTR);
        rd("R2", A_BASE + 8'd14);
        rd("R2", A_BASE + 8'd15);

        // R5: pops return in reverse order, oldest overwritten
        for (int i = 0; i < 8; i++)
            step("R5", 1'b0, 1'b1, 11'd0, 1'b0, A_PTR, 8'h00);
        rd("R3", A_PTR);

        // R3: pop from 7 wraps to 0
        step("R7", 1'b0, 1'b0, 11'd0, 1'b1, A_PTR, 8'h07);
        step("R3", 1'b0, 1'b1, 11'd0, 1'b0, A_PTR, 8'h00);
        rd("R3", A_PTR);

        // R4: push and pop together = push only
        step("R4", 1'b1, 1'b1, 11'h5A5, 1'b0, A_PTR, 8'h00);
        rd("R4", A_PTR);
        rd("R4", A_BASE + 8'd0);
        rd("R4", A_BASE + 8'd1);

        // R7: pointer register write sets enable and pointer
        step("R7", 1'b0, 1'b0, 11'd0, 1'b1, A_PTR, 8'h85);
        rd("R7", A_PTR);

        // R8: unimplemented bits and unmapped addresses
        step("R8", 1'b0, 1'b0, 11'd0, 1'b1, A_PTR, 8'hFF);
        rd("R8", A_PTR);
        step("R8", 1'b0, 1'b0, 11'd0, 1'b1, A_BASE + 8'd5, 8'hFF);
        rd("R8", A_BASE + 8'd5);
        step("R8", 1'b0, 1'b0, 11'd0, 1'b1, 8'h10, 8'hAB);
        rd("R8", 8'h10);
        rd("R8", A_PTR);

        // R6: software fills a slot and a pop returns it
        step("R7", 1'b0, 1'b0, 11'd0, 1'b1, A_PTR, 8'h02);
        step("R6", 1'b0, 1'b0, 11'd0, 1'b1, A_BASE + 8'd6, 8'h3C);
        step("R6", 1'b0, 1'b0, 11'd0, 1'b1, A_BASE + 8'd7, 8'hFE);
        rd("R6", A_BASE + 8'd6);
        rd("R6", A_BASE + 8'd7);
        step("R6", 1'b0, 1'b1, 11'd0, 1'b0, A_PTR, 8'h00);

        // R9: push against pointer write, and against same-slot write
        step("R9", 1'b1, 1'b0, 11'h111, 1'b1, A_PTR, 8'h81);
        rd("R9", A_PTR);
        step("R9", 1'b1, 1'b0, 11'h2F0, 1'b1, A_BASE + 8'd4, 8'h77);
        rd("R9", A_BASE + 8'd4);
        rd("R9", A_BASE + 8'd5);
        step("R9", 1'b0, 1'b1, 11'd0, 1'b1, A_PTR, 8'h04);
        rd("R9", A_PTR);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [7:0] a;
            logic [3:0] sel;
            sel = 4'($urandom_range(0, 15));
            if (sel < 4)       a = A_PTR;
            else if (sel < 14) a = A_BASE + 8'($urandom_range(0, 15));
            else               a = 8'($urandom);
            step("R5", 1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 2) == 0),
                 11'($urandom), 1'($urandom_range(0, 3) == 0), a, 8'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule